// File: doc/BRIEF.md
# Interrupt Request Status and Enable Controller

This block is the front end of an interrupt path for fifteen sources, numbered 1 to 15. Each source has an enable bit. A source can place a bit in the status register only while it is enabled. A single combined interrupt line goes high whenever any status bit is set.

Software reaches the block through a small 32-bit register bus. It changes the enable mask through two write addresses: one where every 1 turns an enable on, and one where every 1 turns an enable off. Writing 0 to a bit of either address leaves that enable as it was, so no read-modify-write is needed. Turning a source off also removes its pending status.

The two lowest sources behave differently from the rest:
- Sources 1 and 2 catch rising edges of their request inputs. Their status bits stay set until software writes a 1 to the matching bit of a dedicated clear address.
- Sources 3 to 15 mirror the enabled request level of their peripheral.

Top module: `irq_front`

## Requirements
- R1: A read at offset 0x000 returns the status of source n in data bit n (n = 1..15), with bit 0 and bits 31:16 reading 0. The read data is all zero whenever the read strobe is low.
- R2: A status bit is never 1 while the enable bit of its source is 0. A request from a disabled source leaves its status at 0.
- R3: A write to offset 0x008 sets enable n for every data bit n (1..15) written as 1. Bits written as 0, bit 0 and bits 31:16 have no effect.
- R4: A write to offset 0x00C clears enable n for every data bit n (1..15) written as 1. Bits written as 0 have no effect.
- R5: The clock edge that clears an enable bit also clears the status bit of that source.
- R6: Reset clears all enable bits, all status bits and the interrupt output.
- R7: Sources 1 and 2 set their status on a rising edge of their request. The status stays set after the request falls. It is cleared by writing 1 to bit 1 or bit 2 at offset 0x004. Other bits written there have no effect.
- R8: If a clear write at 0x004 and a new rising edge of the same source arrive on the same clock edge, the status bit stays set.
- R9: For sources 3 to 15, the status on each clock edge takes the value of the request AND the enable.
- R10: A read at 0x008 or 0x00C returns the enable mask in bits 15:1, with the other bits reading 0. A read at 0x004 returns 0.
- R11: The interrupt output is the OR of the status bits, registered, so it changes one clock edge after the status register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe, gates the read data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| req_in | input | 15 | Request inputs, bit n belongs to source n (index 15:1) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks the following cases:
- A disabled request that still sets status. This would raise a phantom interrupt.
- A disable that leaves status behind. This would keep the line high after software has masked the source.
- A sticky source that latches the level instead of the edge, or clears on the wrong bit. Either fault would lose events or drop one pending event when software clears the other source.
- A clear that arrives in the same cycle as a new edge. A design that gives priority to the clear would lose that new event.
- The interrupt line, sampled one cycle after each status change. This catches a line that is combinational or that lags by two cycles.

// File: rtl/irq_front.sv
module irq_front #(
  parameter int NSRC    = 15,
  parameter int NSTICKY = 2,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC:1]     req_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_SWCLR = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_ENSET = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_ENCLR = ADDR_W'(12'h00C);
  localparam int PAD = 31 - NSRC;

  logic [NSRC:1]    en_q, en_d, sts_q, sts_d;
  logic [NSRC:1]    set_m, clr_m;
  logic [NSTICKY:1] req_q, sw_clr;
  logic             irq_q;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:NSRC+1], bus_wdata[0]};

  assign set_m  = (bus_wr && bus_addr == OFS_ENSET) ? bus_wdata[NSRC:1] : '0;
  assign clr_m  = (bus_wr && bus_addr == OFS_ENCLR) ? bus_wdata[NSRC:1] : '0;
  assign sw_clr = (bus_wr && bus_addr == OFS_SWCLR) ? bus_wdata[NSTICKY:1] : '0;
  assign en_d   = (en_q | set_m) & ~clr_m;

  for (genvar i = 1; i <= NSRC; i++) begin : g_src
    if (i <= NSTICKY) begin : g_sticky
      logic rise;
      assign rise     = req_in[i] & ~req_q[i];
      assign sts_d[i] = en_d[i] & (rise | (sts_q[i] & ~sw_clr[i]));
    end else begin : g_level
      assign sts_d[i] = en_d[i] & req_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
      req_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
      req_q <= req_in[NSTICKY:1];
      irq_q <= |sts_q;
    end
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFS_STAT)
        bus_rdata = {{PAD{1'b0}}, sts_q, 1'b0};
      else if (bus_addr == OFS_ENSET || bus_addr == OFS_ENCLR)
        bus_rdata = {{PAD{1'b0}}, en_q, 1'b0};
    end
  end
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int NSRC    = 15,
  parameter int NSTICKY = 2,
  parameter int ADDR_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [NSRC:1]     req_in,
  input logic [NSRC:1]     en_q,
  input logic [NSRC:1]     sts_q,
  input logic              irq
);
  p_sts_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~en_q) == '0);

  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12'h008)) |=>
      ((en_q & $past(bus_wdata[NSRC:1])) == $past(bus_wdata[NSRC:1])));

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12'h00C)) |=>
      ((en_q & $past(bus_wdata[NSRC:1])) == '0));

  p_dis_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12'h00C)) |=>
      ((sts_q & $past(bus_wdata[NSRC:1])) == '0));

  p_level_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[NSRC:NSTICKY+1] & ~$past(req_in[NSRC:NSTICKY+1])) == '0);

  p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|$past(sts_q)));
endmodule

bind irq_front irq_front_chk #(.NSRC(NSRC), .NSTICKY(NSTICKY), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .req_in(req_in), .en_q(en_q), .sts_q(sts_q), .irq(irq)
);

// File: tb/irq_front_tb.sv
module irq_front_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:1] req_in = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  irq_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_in(req_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d); chk("R6 status after reset", d, 0);
    rd(12'h008, d); chk("R6 enable after reset", d, 0);
    chk("R6 irq after reset", {31'b0, irq}, 0);
    bus_addr = 12'h008; #1;
    chk("R1 rdata zero without strobe", bus_rdata, 0);
  endtask

  task automatic t_enable_access();
    logic [31:0] d;
    wr(12'h008, 32'hFFFF_0001);
    rd(12'h008, d); chk("R3 reserved set bits ignored", d, 0);
    wr(12'h008, 32'h0000_0022);
    rd(12'h008, d); chk("R3 set bits 5 and 1", d, 32'h22);
    wr(12'h008, 32'h0000_0004);
    rd(12'h00C, d); chk("R10 mask via clear address", d, 32'h26);
    wr(12'h00C, 32'h0000_0004);
    rd(12'h008, d); chk("R4 clear bit 2 only", d, 32'h22);
    rd(12'h004, d); chk("R10 swclr reads zero", d, 0);
  endtask

  task automatic t_disabled_req();
    logic [31:0] d;
    @(negedge clk); req_in[7] = 1'b1;
    tick(); tick();
    rd(12'h000, d); chk("R2 disabled source stays clear", d, 0);
    chk("R2 irq stays low", {31'b0, irq}, 0);
    req_in[7] = 1'b0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); req_in[5] = 1'b1;
    tick();
    rd(12'h000, d); chk("R9 level source latched", d, 32'h20);
    chk("R11 irq not yet", {31'b0, irq}, 0);
    tick();
    chk("R11 irq one edge later", {31'b0, irq}, 1);
    req_in[5] = 1'b0;
    tick();
    rd(12'h000, d); chk("R9 status follows drop", d, 0);
    chk("R11 irq still high", {31'b0, irq}, 1);
    tick();
    chk("R11 irq falls", {31'b0, irq}, 0);
  endtask

  task automatic t_disable_clears();
    logic [31:0] d;
    wr(12'h008, 32'h0000_0200);
    @(negedge clk); req_in[9] = 1'b1;
    tick();
    rd(12'h000, d); chk("R9 source 9 active", d, 32'h200);
    wr(12'h00C, 32'h0000_0200);
    rd(12'h000, d); chk("R5 status cleared with enable", d, 0);
    rd(12'h008, d); chk("R4 other enables kept", d, 32'h22);
    req_in[9] = 1'b0;
    tick();
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(12'h008, 32'h0000_0006);
    @(negedge clk); req_in[1] = 1'b1;
    @(negedge clk); req_in[1] = 1'b0;
    tick();
    rd(12'h000, d); chk("R7 sticky after request falls", d, 32'h2);
    @(negedge clk); req_in[2] = 1'b1;
    tick(); tick();
    rd(12'h000, d); chk("R7 held level latches once", d, 32'h6);
    wr(12'h004, 32'h0000_0004);
    rd(12'h000, d); chk("R7 clear of source 2 only", d, 32'h2);
    wr(12'h004, 32'hFFFF_FFF9);
    rd(12'h000, d); chk("R7 other clear bits no effect", d, 32'h2);
    wr(12'h004, 32'h0000_0002);
    rd(12'h000, d); chk("R7 software clear source 1", d, 0);
    req_in[2] = 1'b0;
    tick();
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk); req_in[1] = 1'b1;
    @(negedge clk); req_in[1] = 1'b0;
    tick();
    rd(12'h000, d); chk("R7 relatch source 1", d, 32'h2);
    @(negedge clk);
    bus_addr = 12'h004; bus_wdata = 32'h2; bus_wr = 1'b1; req_in[1] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd(12'h000, d); chk("R8 edge wins over clear", d, 32'h2);
    req_in[1] = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_access();
    t_disabled_req();
    t_level();
    t_disable_clears();
    t_sticky();
    t_collision();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule